// File: doc/BRIEF.md
# Request-Driven Single-Transfer Move Engine

This block moves data one item at a time, from a source address to a destination address. It starts a new move only when a service request arrives. Software first loads a small control block. The block holds a transfer count, a control byte, and starting source and destination addresses. Each request then causes one memory read from the source address, followed in the next cycle by one memory write of the same data to the destination address. The count then drops by one.

The control byte selects the transfer size (byte or 16-bit word). For each of the two addresses it also sets two flags:
- whether the address steps forward after each move;
- whether the stepped address is kept, or the starting address is reloaded.

A one-cycle end-of-run interrupt fires after the final write, and the engine then ignores requests until it is loaded again. The engine does not run, and instead raises a sticky error flag, in two cases: a malformed control byte, or a word move at an odd address.

Top module: `xfer_server`

## Requirements
- R1: A load pulse while the engine is idle captures the count, the control byte and both addresses, and clears the error flag. A load pulse while busy is ignored. After reset, mem_rd, mem_wr, done_irq, err and busy are all low.
- R2: The control byte is laid out as follows: bits [7:5] are the mode, bit 4 is the size, bit 3 is source-keep, bit 2 is destination-keep, bit 1 is source-step and bit 0 is destination-step. It is accepted only if the mode is 3'b100, source-keep equals source-step, and destination-keep equals destination-step. Otherwise err is set at load and no bus cycle follows any request.
- R3: A serviced request produces exactly one cycle with mem_rd high and mem_addr equal to the current source address. The next cycle has mem_wr high, mem_addr equal to the current destination address, and mem_wdata equal to the data read. mem_rd and mem_wr are never high together, and busy is high during both cycles.
- R4: Size bit 0 selects word moves: 16 bits, with mem_byte low. Size bit 1 selects byte moves: mem_byte is high, and mem_wdata carries the read byte in bits [7:0] with zeros above.
- R5: When an address's keep and step flags are both 1, that address advances after each move, by 2 for words and by 1 for bytes.
- R6: When an address's keep and step flags are both 0, that address returns to its loaded value after each move, so every move uses the same address.
- R7: Each completed move decrements the count. The move that brings the count to zero raises done_irq for exactly one cycle, in the cycle after its write. Requests after that produce no bus cycles until the next load.
- R8: A request that arrives while a move is in progress is held and serviced after it. A held request uses up one count, as an immediate request would.
- R9: In word mode, a serviced request with an odd source or destination address makes no bus cycle. It sets err and stops the engine until the next load.
- R10: A load with a count of zero makes later requests produce no bus cycles and no done_irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Load control block (taken only when idle) |
| load_count | input | 8 | Number of moves to perform |
| load_ctrl | input | 8 | Control byte |
| load_src | input | 16 | Starting source address |
| load_dst | input | 16 | Starting destination address |
| req | input | 1 | Service request, one move per cycle held high |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory byte address |
| mem_byte | output | 1 | High for a byte access, low for a word access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the same cycle as mem_rd |
| done_irq | output | 1 | One-cycle end-of-run interrupt |
| err | output | 1 | Sticky error flag, cleared by load |
| busy | output | 1 | High while a read or write cycle is under way |

## Verification
The main function is tried with four address patterns:
- a fixed word source feeding a stepping destination;
- byte moves with both addresses stepping;
- byte moves from a stepping source into a fixed destination;
- word moves with both addresses reloading.

Together these separate a step of 2 from a step of 1, stepping from reloading, and word data from zero-extended byte data. A request held high across two edges checks that a request arriving mid-move is held, and that the leftover count still ends the run with exactly one interrupt. Malformed control bytes, odd word addresses and a zero count each check that no bus cycle appears at all.

// File: rtl/xs_pkg.sv
package xs_pkg;

    localparam logic [2:0] MODE_SINGLE = 3'b100;

    // control byte, most significant field first
    typedef struct packed {
        logic [2:0] mode;
        logic       byte_sz;
        logic       src_keep;
        logic       dst_keep;
        logic       src_inc;
        logic       dst_inc;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } state_t;

    function automatic logic ctrl_ok(input ctrl_t c);
        return (c.mode == MODE_SINGLE) &&
               (c.src_keep == c.src_inc) &&
               (c.dst_keep == c.dst_inc);
    endfunction

endpackage

// File: rtl/xs_ctrl_decode.sv
module xs_ctrl_decode
    import xs_pkg::*;
(
    input  logic [7:0] raw,
    output ctrl_t      fields,
    output logic       valid
);
    always_comb begin
        fields = ctrl_t'(raw);
        valid  = ctrl_ok(fields);
    end
endmodule

// File: rtl/xs_addr_unit.sv
module xs_addr_unit #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          advance,
    input  logic          keep,
    input  logic          inc,
    input  logic          byte_sz,
    output logic [AW-1:0] cur
);
    localparam int PADW = AW - 2;

    logic [AW-1:0] cur_q, base_q, step;

    assign step = {{PADW{1'b0}}, ~byte_sz, byte_sz};

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            base_q <= '0;
        end else if (load) begin
            cur_q  <= load_addr;
            base_q <= load_addr;
        end else if (advance) begin
            if (keep)
                cur_q <= inc ? cur_q + step : cur_q;
            else
                cur_q <= base_q;
        end
    end

    assign cur = cur_q;
endmodule

// File: rtl/xs_seq.sv
module xs_seq
    import xs_pkg::*;
#(
    parameter int CW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_count,
    input  logic          cfg_valid,
    input  logic          byte_sz,
    input  logic          req,
    input  logic          misaligned,
    input  logic [DW-1:0] rdata,
    output state_t        state,
    output logic [DW-1:0] data,
    output logic          irq,
    output logic          err
);
    localparam int HIW = DW - 8;

    state_t        state_q;
    logic [CW-1:0] count_q;
    logic          active_q, pend_q, err_q, irq_q;
    logic [DW-1:0] data_q;
    logic          start;

    assign start = (state_q == ST_IDLE) && active_q && (req || pend_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            count_q  <= '0;
            active_q <= 1'b0;
            pend_q   <= 1'b0;
            err_q    <= 1'b0;
            irq_q    <= 1'b0;
            data_q   <= '0;
        end else begin
            irq_q <= 1'b0;
            if (load) begin
                count_q  <= load_count;
                active_q <= cfg_valid && (load_count != '0);
                err_q    <= ~cfg_valid;
                pend_q   <= 1'b0;
            end else begin
                case (state_q)
                    ST_IDLE: begin
                        if (start) begin
                            pend_q <= 1'b0;
                            if (misaligned) begin
                                err_q    <= 1'b1;
                                active_q <= 1'b0;
                            end else begin
                                state_q <= ST_READ;
                            end
                        end
                    end
                    ST_READ: begin
                        data_q  <= byte_sz ? {{HIW{1'b0}}, rdata[7:0]} : rdata;
                        state_q <= ST_WRITE;
                        if (req) pend_q <= 1'b1;
                    end
                    ST_WRITE: begin
                        state_q <= ST_IDLE;
                        count_q <= count_q - 1'b1;
                        if (req) pend_q <= 1'b1;
                        if (count_q == {{(CW-1){1'b0}}, 1'b1}) begin
                            active_q <= 1'b0;
                            irq_q    <= 1'b1;
                            pend_q   <= 1'b0;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign state = state_q;
    assign data  = data_q;
    assign irq   = irq_q;
    assign err   = err_q;
endmodule

// File: rtl/xfer_server.sv
module xfer_server
    import xs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_count,
    input  logic [7:0]    load_ctrl,
    input  logic [AW-1:0] load_src,
    input  logic [AW-1:0] load_dst,
    input  logic          req,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic          mem_byte,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          done_irq,
    output logic          err,
    output logic          busy
);
    localparam int NSIDE = 2;   // 0: source, 1: destination

    ctrl_t         dec;
    logic          dec_ok;
    state_t        state;
    logic          load_acc;
    logic          byte_q;
    logic [NSIDE-1:0] keep_q, inc_q;
    logic [AW-1:0] side_load [NSIDE];
    logic [AW-1:0] side_cur  [NSIDE];
    logic          misaligned;

    xs_ctrl_decode u_dec (.raw(load_ctrl), .fields(dec), .valid(dec_ok));

    assign load_acc = load && (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_q <= 1'b0;
            keep_q <= '0;
            inc_q  <= '0;
        end else if (load_acc) begin
            byte_q <= dec.byte_sz;
            keep_q <= {dec.dst_keep, dec.src_keep};
            inc_q  <= {dec.dst_inc, dec.src_inc};
        end
    end

    assign side_load[0] = load_src;
    assign side_load[1] = load_dst;

    for (genvar i = 0; i < NSIDE; i++) begin : g_side
        xs_addr_unit #(.AW(AW)) u_addr (
            .clk      (clk),
            .rst      (rst),
            .load     (load_acc),
            .load_addr(side_load[i]),
            .advance  (state == ST_WRITE),
            .keep     (keep_q[i]),
            .inc      (inc_q[i]),
            .byte_sz  (byte_q),
            .cur      (side_cur[i])
        );
    end

    assign misaligned = ~byte_q && (side_cur[0][0] || side_cur[1][0]);

    xs_seq #(.CW(CW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .load      (load_acc),
        .load_count(load_count),
        .cfg_valid (dec_ok),
        .byte_sz   (byte_q),
        .req       (req),
        .misaligned(misaligned),
        .rdata     (mem_rdata),
        .state     (state),
        .data      (mem_wdata),
        .irq       (done_irq),
        .err       (err)
    );

    assign mem_rd   = (state == ST_READ);
    assign mem_wr   = (state == ST_WRITE);
    assign mem_addr = (state == ST_WRITE) ? side_cur[1] : side_cur[0];
    assign mem_byte = byte_q;
    assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/xs_chk.sv
module xs_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] mem_addr,
    input logic          mem_byte,
    input logic          done_irq,
    input logic          err,
    input logic          busy
);
    p_rw_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    p_wr_after_rd_r3: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> mem_wr);

    p_wr_needs_rd_r3: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> $past(mem_rd));

    p_busy_bus_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |-> busy);

    p_even_word_r9: assert property (@(posedge clk) disable iff (rst)
        ((mem_rd || mem_wr) && !mem_byte) |-> !mem_addr[0]);

    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done_irq |=> !done_irq);

    p_irq_after_wr_r7: assert property (@(posedge clk) disable iff (rst)
        done_irq |-> $past(mem_wr));

    p_err_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        err |-> (!mem_rd && !mem_wr));
endmodule

bind xfer_server xs_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr),
    .mem_addr(mem_addr),
    .mem_byte(mem_byte),
    .done_irq(done_irq),
    .err     (err),
    .busy    (busy)
);

// File: tb/tb_xfer_server.sv
`timescale 1ns/1ps
module tb_xfer_server;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [7:0]  load_count = '0;
    logic [7:0]  load_ctrl = '0;
    logic [15:0] load_src = '0;
    logic [15:0] load_dst = '0;
    logic        req = 1'b0;
    logic        mem_rd, mem_wr, mem_byte, done_irq, err, busy;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;

    always #2 clk = ~clk;   // 250 MHz

    xfer_server dut (.*);

    // byte-addressed memory model, 256 bytes
    logic [7:0] mem [0:255];
    logic [7:0] ra;
    assign ra = mem_addr[7:0];
    assign mem_rdata = {mem[ra + 8'd1], mem[ra]};
    always @(posedge clk) begin
        if (mem_wr) begin
            mem[ra] <= mem_wdata[7:0];
            if (!mem_byte) mem[ra + 8'd1] <= mem_wdata[15:8];
        end
    end

    typedef struct { logic [15:0] addr; logic [15:0] data; logic bsz; } item_t;
    item_t exp_q[$];
    int n_chk = 0, n_fail = 0;
    int rd_seen = 0, irq_seen = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares every write against the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_rd) rd_seen++;
            if (done_irq) irq_seen++;
            if (mem_wr) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected write", {16'h0, mem_addr}, 32'h0);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    check(mem_addr == e.addr, "R5/R6 write address", {16'h0, mem_addr}, {16'h0, e.addr});
                    check(mem_wdata == e.data, "R3/R4 write data", {16'h0, mem_wdata}, {16'h0, e.data});
                    check(mem_byte == e.bsz, "R4 size", {31'h0, mem_byte}, {31'h0, e.bsz});
                end
            end
        end
    end

    task automatic push(input logic [15:0] a, input logic [15:0] d, input logic b);
        item_t it;
        it.addr = a; it.data = d; it.bsz = b;
        exp_q.push_back(it);
    endtask

    task automatic load_cb(input logic [7:0] c, input logic [7:0] ct, input logic [15:0] s, input logic [15:0] d);
        @(posedge clk); #1;
        load = 1'b1; load_count = c; load_ctrl = ct; load_src = s; load_dst = d;
        @(posedge clk); #1;
        load = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 req = 1'b1;
            @(posedge clk); #1 req = 1'b0;
            repeat (4) @(posedge clk);
        end
        repeat (4) @(posedge clk);
    endtask

    task automatic drained(input string tag);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int r0, q0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        mem[8'h20] = 8'hEF; mem[8'h21] = 8'hBE;
        for (int i = 0; i < 4; i++) mem[8'h30 + i] = 8'(8'h11 * (i + 1));
        mem[8'h40] = 8'h5A; mem[8'h41] = 8'hC3;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check({mem_rd, mem_wr, done_irq, err, busy} == 5'b0, "R1 reset outputs",
              {27'h0, mem_rd, mem_wr, done_irq, err, busy}, 0);

        // R5/R7: word, fixed source, stepping destination (ctrl 0x85)
        load_cb(8'd3, 8'h85, 16'h0020, 16'h0060);
        check(err == 1'b0, "R1 valid load clears err", {31'h0, err}, 0);
        q0 = irq_seen;
        for (int i = 0; i < 3; i++) push(16'h0060 + 16'(2 * i), 16'hBEEF, 1'b0);
        run(3);
        drained("R5 word stepping writes done");
        check(irq_seen - q0 == 1, "R7 one interrupt", irq_seen - q0, 1);
        check({mem[8'h65], mem[8'h64]} == 16'hBEEF, "R3 memory word", {mem[8'h65], mem[8'h64]}, 16'hBEEF);
        r0 = rd_seen;
        run(2);
        check(rd_seen == r0, "R7 requests after end ignored", rd_seen - r0, 0);

        // R4/R5: byte, both stepping (ctrl 0x9F)
        load_cb(8'd4, 8'h9F, 16'h0030, 16'h0080);
        for (int i = 0; i < 4; i++) push(16'h0080 + 16'(i), {8'h00, 8'(8'h11 * (i + 1))}, 1'b1);
        run(4);
        drained("R4 byte stepping writes done");
        check(mem[8'h83] == 8'h44, "R4 memory byte", mem[8'h83], 8'h44);

        // R6: byte, stepping source into fixed destination (ctrl 0x9A)
        load_cb(8'd3, 8'h9A, 16'h0030, 16'h00A0);
        for (int i = 0; i < 3; i++) push(16'h00A0, {8'h00, 8'(8'h11 * (i + 1))}, 1'b1);
        run(3);
        drained("R6 fixed destination writes done");
        check(mem[8'hA0] == 8'h33, "R6 last byte in fixed dst", mem[8'hA0], 8'h33);

        // R6: word, both reloading (ctrl 0x80)
        load_cb(8'd2, 8'h80, 16'h0040, 16'h0090);
        push(16'h0090, 16'hC35A, 1'b0); push(16'h0090, 16'hC35A, 1'b0);
        run(2);
        drained("R6 reload writes done");

        // R8: request held across two edges, count 5
        load_cb(8'd5, 8'h85, 16'h0020, 16'h00C0);
        q0 = irq_seen;
        r0 = rd_seen;
        push(16'h00C0, 16'hBEEF, 1'b0); push(16'h00C2, 16'hBEEF, 1'b0);
        @(posedge clk); #1 req = 1'b1;
        @(posedge clk);
        @(posedge clk); #1 req = 1'b0;
        repeat (8) @(posedge clk);
        check(rd_seen - r0 == 2, "R8 pending request serviced", rd_seen - r0, 2);
        drained("R8 pending writes done");
        check(irq_seen == q0, "R8 no early interrupt", irq_seen - q0, 0);
        for (int i = 2; i < 5; i++) push(16'h00C0 + 16'(2 * i), 16'hBEEF, 1'b0);
        run(3);
        drained("R8 remaining count");
        check(irq_seen - q0 == 1, "R7 interrupt after remainder", irq_seen - q0, 1);

        // R2: bad mode, then pairing violation
        load_cb(8'd2, 8'h65, 16'h0020, 16'h0060);
        check(err == 1'b1, "R2 bad mode sets err", {31'h0, err}, 1);
        r0 = rd_seen;
        run(1);
        check(rd_seen == r0, "R2 bad mode no bus", rd_seen - r0, 0);
        load_cb(8'd2, 8'h81, 16'h0020, 16'h0060);
        check(err == 1'b1, "R2 unpaired flags set err", {31'h0, err}, 1);
        run(1);
        check(rd_seen == r0, "R2 unpaired no bus", rd_seen - r0, 0);

        // R9: odd word address
        load_cb(8'd2, 8'h85, 16'h0021, 16'h0060);
        check(err == 1'b0, "R1 load clears err", {31'h0, err}, 0);
        run(2);
        check(err == 1'b1, "R9 odd word sets err", {31'h0, err}, 1);
        check(rd_seen == r0, "R9 odd word no bus", rd_seen - r0, 0);

        // R10: zero count
        load_cb(8'd0, 8'h85, 16'h0020, 16'h0060);
        q0 = irq_seen;
        run(2);
        check(rd_seen == r0, "R10 zero count no bus", rd_seen - r0, 0);
        check(irq_seen == q0, "R10 zero count no interrupt", irq_seen - q0, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule